// File: doc/BRIEF.md
# Keyboard Scan-Code Receiver with Host FIFO

This block listens to a two-wire keyboard port on which the keyboard itself produces the clock. Both lines are brought into the system clock domain through two flip-flops, and a small debounce filter keeps short spikes on the clock line from counting as bits. On each falling edge of the filtered clock, the data line is shifted into a frame register. When all 11 bits of a frame have arrived, the frame is checked. A frame that passes its checks delivers its byte to a 16-entry first-in first-out queue.

A host bus master reaches the block through a two-address register port. One address holds a status word. The other is a data port, and each read of it removes one byte from the queue. The interrupt request stays high for as long as at least one byte is waiting. Scan codes pass through exactly as received, prefixes included, and the host does all decoding. If a frame stops partway through for longer than the timeout, the partial frame is discarded, so it cannot spoil the frame that follows.

Top module: `kbd_rx_fifo`

## Requirements
- R1: After reset the status word reads 0x00, `irq_o` is low, and a read of the data port returns 0x00.
- R2: A frame carries 11 bits sampled on falling clock edges: a start bit of 0, then 8 data bits least significant first, then a parity bit that makes the count of ones among the data and parity bits odd, then a stop bit of 1. A frame that meets all three rules is stored as one byte.
- R3: A frame with a start bit of 1, a stop bit of 0 or even parity stores nothing and sets the error flag, status bit 2. The flag stays set until the host clears it.
- R4: The queue holds up to 16 bytes, and the host reads them back in the order they arrived.
- R5: A valid byte that arrives while 16 bytes are already waiting is discarded and sets the overflow flag, status bit 1. The flag stays set until the host clears it. The bytes already queued are not changed.
- R6: A write to address 0 clears the overflow flag when data bit 1 is 1 and clears the error flag when data bit 2 is 1. Other bits have no effect. If a clear and a new event fall in the same cycle, the flag stays set.
- R7: A read of address 1 returns the oldest byte and removes it from the queue. A read of address 1 when the queue is empty returns 0x00 and changes no state. A read of address 0 removes nothing.
- R8: Status bit 0 and `irq_o` are high exactly when the queue holds at least one byte.
- R9: If a frame has started and the clock line shows no falling edge for `TMO_CYC` cycles, the bits gathered so far are dropped. The next frame is then received from its start bit.
- R10: The prefix bytes 0xE0 and 0xF0 are stored and returned unchanged, in sequence with the codes around them.
- R11: When a byte is stored and the host removes a byte in the same cycle, both take effect. No byte is lost, repeated or reordered.
- R12: A low pulse on the keyboard clock line that is shorter than `FILT_CYC` system cycles does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kb_clk_i | input | 1 | Clock line driven by the keyboard |
| kb_dat_i | input | 1 | Data line driven by the keyboard |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = status word, 1 = data port |
| bus_wdata_i | input | 8 | Write data (bit 1 clears overflow, bit 2 clears error) |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | High while the queue is not empty |

## Verification
Two events can land in the same cycle: a completed frame being stored, and a host read removing a byte. To make them collide, the bench fills the queue with twelve codes and then sends one more. Starting at the falling edge of that frame's stop bit, it reads the data port once per cycle for fourteen cycles. The store then falls somewhere inside this run of reads. The bench judges the result by the sequence read back: the twelve older codes in order, then the new code, then 0x00 with `irq_o` low. A lost, repeated or reordered byte shows up as a mismatch.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int CODE_W     = 8;
    localparam int ST_AVAIL   = 0;
    localparam int ST_OVF     = 1;
    localparam int ST_ERR     = 2;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kb_clk_i,
    input  logic kb_dat_i,
    output logic fall_o,
    output logic dat_o
);
    localparam int FW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic          c1;
        logic          c2;
        logic          d1;
        logic          d2;
        logic          lvl;
        logic [FW-1:0] cnt;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  fall_d;

    always_comb begin
        sync_d    = sync_q;
        fall_d    = 1'b0;
        sync_d.c1 = kb_clk_i;
        sync_d.c2 = sync_q.c1;
        sync_d.d1 = kb_dat_i;
        sync_d.d2 = sync_q.d1;
        if (sync_q.c2 != sync_q.lvl) begin
            if (sync_q.cnt == FW'(FILT_CYC - 1)) begin
                sync_d.lvl = sync_q.c2;
                sync_d.cnt = '0;
                fall_d     = sync_q.lvl;
            end else begin
                sync_d.cnt = sync_q.cnt + FW'(1);
            end
        end else begin
            sync_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{c1: 1'b1, c2: 1'b1, d1: 1'b1, d2: 1'b1, lvl: 1'b1, cnt: '0};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign fall_o = fall_d;
    assign dat_o  = sync_q.d2;

    // R12
    filt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !sync_q.lvl);
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
    import kbd_rx_pkg::*;
#(
    parameter int TMO_CYC = 100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              dat_i,
    output logic              vld_o,
    output logic              err_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int TW = $clog2(TMO_CYC + 1);

    typedef struct packed {
        logic [3:0]        cnt;
        logic [9:0]        sh;
        logic [TW-1:0]     idle;
        logic              vld;
        logic              err;
        logic [CODE_W-1:0] code;
    } frm_t;

    frm_t frm_d, frm_q;
    logic ok;

    always_comb begin
        frm_d     = frm_q;
        frm_d.vld = 1'b0;
        frm_d.err = 1'b0;
        ok        = 1'b0;
        if (fall_i) begin
            frm_d.idle = '0;
            if (frm_q.cnt == 4'(FRAME_BITS - 1)) begin
                // sh[0]=start, sh[8:1]=data, sh[9]=parity, dat_i=stop
                ok         = !frm_q.sh[0] && dat_i && (^frm_q.sh[9:1]);
                frm_d.cnt  = '0;
                frm_d.code = frm_q.sh[8:1];
                frm_d.vld  = ok;
                frm_d.err  = !ok;
            end else begin
                frm_d.sh  = {dat_i, frm_q.sh[9:1]};
                frm_d.cnt = frm_q.cnt + 4'd1;
            end
        end else if (frm_q.cnt != 4'd0) begin
            if (frm_q.idle == TW'(TMO_CYC - 1)) begin
                frm_d.cnt  = '0;
                frm_d.idle = '0;
            end else begin
                frm_d.idle = frm_q.idle + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign vld_o  = frm_q.vld;
    assign err_o  = frm_q.err;
    assign code_o = frm_q.code;

    // R2
    frame_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o || err_o) |-> $past(fall_i));
    // R9
    stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.cnt != 4'd0 && !fall_i && frm_q.idle == TW'(TMO_CYC - 1)) |=> (frm_q.cnt == 4'd0));
endmodule

// File: rtl/kbd_code_fifo.sv
module kbd_code_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         ovf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic [PW-1:0] count;
    logic full, empty;

    always_comb begin
        count  = fifo_q.wr - fifo_q.rd;
        full   = (count == PW'(DEPTH));
        empty  = (count == '0);
        fifo_d = fifo_q;
        if (push_i && !full) begin
            fifo_d.mem[fifo_q.wr[AW-1:0]] = din_i;
            fifo_d.wr = fifo_q.wr + PW'(1);
        end
        if (pop_i && !empty) begin
            fifo_d.rd = fifo_q.rd + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign dout_o  = empty ? '0 : fifo_q.mem[fifo_q.rd[AW-1:0]];
    assign empty_o = empty;
    assign ovf_o   = push_i && full;

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full) |=> $stable(fifo_q.wr));
    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty) |=> $stable(fifo_q.rd));
    // R11
    push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty && !full) |=> $stable(count));
endmodule

// File: rtl/kbd_rx_fifo.sv
module kbd_rx_fifo
    import kbd_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int FILT_CYC   = 4,
    parameter int TMO_CYC    = 100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_clk_i,
    input  logic              kb_dat_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic              bus_addr_i,
    input  logic [CODE_W-1:0] bus_wdata_i,
    output logic [CODE_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic ovf;
        logic err;
    } flag_t;

    flag_t flag_d, flag_q;
    logic fall, dat, vld, ferr, empty, ovf_ev, pop, clr_ovf, clr_err;
    logic [CODE_W-1:0] code, head;

    kbd_line_sync #(.FILT_CYC(FILT_CYC)) u_sync (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk_i), .kb_dat_i(kb_dat_i),
        .fall_o(fall), .dat_o(dat)
    );

    kbd_frame_rx #(.TMO_CYC(TMO_CYC)) u_frame (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .dat_i(dat),
        .vld_o(vld), .err_o(ferr), .code_o(code)
    );

    kbd_code_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(vld), .din_i(code), .pop_i(pop),
        .dout_o(head), .empty_o(empty), .ovf_o(ovf_ev)
    );

    always_comb begin
        pop     = bus_sel_i && !bus_we_i && bus_addr_i;
        clr_ovf = bus_sel_i && bus_we_i && !bus_addr_i && bus_wdata_i[ST_OVF];
        clr_err = bus_sel_i && bus_we_i && !bus_addr_i && bus_wdata_i[ST_ERR];
        flag_d.ovf = (flag_q.ovf && !clr_ovf) || ovf_ev;
        flag_d.err = (flag_q.err && !clr_err) || ferr;
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_we_i) begin
            if (bus_addr_i) begin
                bus_rdata_o = head;
            end else begin
                bus_rdata_o[ST_AVAIL] = !empty;
                bus_rdata_o[ST_OVF]   = flag_q.ovf;
                bus_rdata_o[ST_ERR]   = flag_q.err;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign irq_o = !empty;

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q.ovf && !clr_ovf) |=> flag_q.ovf);
    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ferr |=> flag_q.err);
endmodule

// File: tb/kbd_rx_fifo_bench.sv
module kbd_rx_fifo_bench;
    localparam int TMO = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kb_clk = 1'b1;
    logic       kb_dat = 1'b1;
    logic       sel = 1'b0;
    logic       we = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];
    logic       done = 1'b0;

    always #10 clk = ~clk;

    kbd_rx_fifo #(.FIFO_DEPTH(16), .FILT_CYC(4), .TMO_CYC(TMO)) u_kbd_rx_fifo (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        kb_dat = b;
        repeat (12) @(negedge clk);
        kb_clk = 1'b0;
        repeat (25) @(negedge clk);
        kb_clk = 1'b1;
        repeat (13) @(negedge clk);
    endtask

    task automatic send_raw(input logic [7:0] b, input bit bad_start, input bit bad_par, input bit bad_stop);
        send_bit(bad_start);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit(~(^b) ^ bad_par);
        send_bit(~bad_stop);
        kb_dat = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    // driver: record what the queue should hold, then send
    task automatic send_code(input logic [7:0] b);
        if (exp_q.size() < 16) exp_q.push_back(b);
        send_raw(b, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd_status(output logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = 1'b0;
        #1 v = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    // monitor: pop one result and compare with the scoreboard
    task automatic pop_cmp(input string req, input bit hold);
        logic [7:0] e;
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = 1'b1;
        #1;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        check(rdata == e, req, rdata, e);
        if (!hold) begin
            @(negedge clk);
            sel = 1'b0;
        end
    endtask

    task automatic wr_status(input logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = 1'b0; wdata = v;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = 8'h00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] st;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd_status(st);
        check(st == 8'h00, "R1 status", st, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        pop_cmp("R1 empty data", 1'b0);

        // R2 R8 single valid frame
        send_code(8'h1C);
        check(irq == 1'b1, "R8 irq high", irq, 1);
        rd_status(st);
        check(st == 8'h01, "R8 status avail", st, 1);
        pop_cmp("R2 byte", 1'b0);
        check(irq == 1'b0, "R8 irq low", irq, 0);

        // R7 empty read changes nothing
        pop_cmp("R7 empty read", 1'b0);
        rd_status(st);
        check(st == 8'h00, "R7 status after empty read", st, 0);

        // R10 R4 prefixes and order
        send_code(8'hE0); send_code(8'hF0); send_code(8'h75);
        pop_cmp("R10 E0", 1'b0);
        pop_cmp("R10 F0", 1'b0);
        pop_cmp("R4 order", 1'b0);

        // R3 bad frames
        send_raw(8'h33, 1'b0, 1'b1, 1'b0);
        rd_status(st);
        check(st == 8'h04, "R3 parity err", st, 8'h04);
        wr_status(8'h04);
        send_raw(8'h33, 1'b0, 1'b0, 1'b1);
        rd_status(st);
        check(st == 8'h04, "R3 stop err", st, 8'h04);
        wr_status(8'h04);
        send_raw(8'h33, 1'b1, 1'b0, 1'b0);
        rd_status(st);
        check(st == 8'h04, "R3 start err", st, 8'h04);
        check(irq == 1'b0, "R3 nothing stored", irq, 0);
        // R6 clear error, other bits ignored
        wr_status(8'h02);
        rd_status(st);
        check(st == 8'h04, "R6 wrong bit keeps err", st, 8'h04);
        wr_status(8'h04);
        rd_status(st);
        check(st == 8'h00, "R6 err cleared", st, 0);

        // R12 glitch on clock line
        @(negedge clk); kb_clk = 1'b0;
        repeat (2) @(negedge clk); kb_clk = 1'b1;
        repeat (20) @(negedge clk);
        send_code(8'h5A);
        pop_cmp("R12 glitch ignored", 1'b0);

        // R9 stalled partial frame
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        kb_dat = 1'b1;
        repeat (TMO + 500) @(negedge clk);
        send_code(8'h29);
        pop_cmp("R9 after stall", 1'b0);
        rd_status(st);
        check(st == 8'h00, "R9 no err", st, 0);

        // R5 overflow
        for (int i = 0; i < 17; i++) send_code(8'h10 + 8'(i));
        rd_status(st);
        check(st == 8'h03, "R5 ovf status", st, 8'h03);
        for (int i = 0; i < 16; i++) pop_cmp("R5 kept bytes", 1'b0);
        check(irq == 1'b0, "R5 17th dropped", irq, 0);
        wr_status(8'h02);
        rd_status(st);
        check(st == 8'h00, "R6 ovf cleared", st, 0);

        // R11 store and remove in the same cycle
        for (int i = 0; i < 12; i++) send_code(8'h40 + 8'(i));
        fork
            send_code(8'h6B);
            begin
                repeat (10 * 50 + 12) @(negedge clk);
                for (int i = 0; i < 14; i++) pop_cmp("R11 drain", 1'b1);
                @(negedge clk);
                sel = 1'b0;
            end
        join
        check(irq == 1'b0, "R11 drained", irq, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule